// File: doc/BRIEF.md
# Prioritized Interrupt Level Encoder

This block gathers thirteen level-sensitive interrupt request lines from board peripherals and turns them into one 4-bit encoded interrupt level for a processor. Every request line has a fixed bit in a 16-bit pending vector and its own fixed priority level. A programmable 16-bit enable mask gates the pending vector. Among the requests that are both raised and enabled, the lowest priority level wins. The output carries that level XOR 15, so the idle code is 0 and level 0 gives 15.

A simple 16-bit register port decodes a 64-byte window. The window holds the enable mask, a general-purpose output register that drives pins, a constant identification register, and a power-down control. A write to the power-down control with bit 0 set gives a single-cycle shutdown request. Reads decode the address combinationally and do not depend on the strobe. Every offset that is not decoded reads zero and ignores writes.

Top module: `irq_level_ctrl`

## Requirements
- R1: Request line `src_req[k]` has priority level k. Its pending/enable bit position for k = 0..12 is, in order: 11, 9, 8, 12, 10, 6, 5, 4, 7, 14, 13, 0, 15. Mask bits 1, 2 and 3 gate no request.
- R2: Requests are not latched. When a request line drops, its contribution is removed at the next rising edge.
- R3: The winning level is the smallest k whose line is high and whose enable bit is 1. `irq_level` shows that level XOR 15, so level 0 gives 15 and level 12 gives 3.
- R4: When no request is both raised and enabled, `irq_level` is 0.
- R5: The enable mask is read/write at byte offset 0x00. A mask write changes `irq_level` at the same rising edge that stores the mask.
- R6: The output register at offset 0x36 is read/write storage, and `out_port` shows its value. A write there has no other effect.
- R7: Offset 0x30 always reads 0. A write there with bit 0 set makes `shutdown_req` high for exactly the one cycle after the write edge. A write with bit 0 clear makes no pulse.
- R8: Offset 0x32 always reads 0x0010. Writes to it have no effect.
- R9: All other offsets in the window read 0. Writes to them change no register and make no shutdown pulse.
- R10: After reset the mask and the output register are 0, and `irq_level` and `shutdown_req` are 0.
- R11: `irq_level` is registered. A change on the request lines shows at the first rising edge after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | 13 | Level request lines; index is the priority level |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset in the window |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| irq_level | output | 4 | Encoded interrupt level (winning level XOR 15) |
| out_port | output | 16 | Contents of the general output register |
| shutdown_req | output | 1 | One-cycle power-down request |

## Verification
The assertions check these relations on every cycle: a pending vector with no bits set gives an idle output, the top-priority line always wins, the shutdown pulse matches a qualifying write one cycle earlier, mask writes are stored, the output register holds between writes, and the identification register is constant. The arbitration order across all combinations cannot be shown by these local properties; only the bench's scenarios show it. The bench sweeps every one of the 8192 request patterns under several masks. Its scenarios also show the timing of a mask write against the level it unmasks, and that writes to undecoded offsets leave nothing behind.

// File: rtl/irqlvl_pkg.sv
package irqlvl_pkg;
  localparam int SRC_N  = 13;
  localparam int LVL_W  = 4;
  localparam int REG_W  = 16;
  localparam int ADDR_W = 6;

  localparam logic [LVL_W-1:0] LVL_NONE = {LVL_W{1'b1}};

  localparam logic [ADDR_W-1:0] OFS_MASK = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_PWR  = 6'h30;
  localparam logic [ADDR_W-1:0] OFS_ID   = 6'h32;
  localparam logic [ADDR_W-1:0] OFS_GPO  = 6'h36;
  localparam logic [REG_W-1:0]  ID_VALUE = 16'h0010;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_MASK,
    SEL_PWR,
    SEL_ID,
    SEL_GPO
  } reg_sel_e;

  // Pending-vector bit position that belongs to the given priority level
  function automatic int bit_of_level(input int lvl);
    case (lvl)
      0:  return 11;
      1:  return 9;
      2:  return 8;
      3:  return 12;
      4:  return 10;
      5:  return 6;
      6:  return 5;
      7:  return 4;
      8:  return 7;
      9:  return 14;
      10: return 13;
      11: return 0;
      12: return 15;
      default: return -1;
    endcase
  endfunction

  // Inverse lookup: which level feeds a pending bit, -1 for none
  function automatic int level_of_bit(input int b);
    int r;
    r = -1;
    for (int k = 0; k < SRC_N; k++)
      if (bit_of_level(k) == b) r = k;
    return r;
  endfunction

  // Lowest level whose hit flag is set, LVL_NONE when none
  function automatic logic [LVL_W-1:0] lowest_hit(input logic [SRC_N-1:0] hits);
    logic [LVL_W-1:0] r;
    r = LVL_NONE;
    for (int k = SRC_N - 1; k >= 0; k--)
      if (hits[k]) r = LVL_W'(k);
    return r;
  endfunction

  // Output code presented to the processor
  function automatic logic [LVL_W-1:0] level_code(input logic [LVL_W-1:0] lvl);
    return lvl ^ LVL_NONE;
  endfunction

  function automatic reg_sel_e decode_ofs(input logic [ADDR_W-1:0] a);
    case (a)
      OFS_MASK: return SEL_MASK;
      OFS_PWR:  return SEL_PWR;
      OFS_ID:   return SEL_ID;
      OFS_GPO:  return SEL_GPO;
      default:  return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/irqlvl_srcmap.sv
module irqlvl_srcmap
  import irqlvl_pkg::*;
(
  input  logic [SRC_N-1:0] src_req,
  output logic [REG_W-1:0] mon_vec
);
  // Each request line drives its fixed bit; unused bits read as zero
  for (genvar b = 0; b < REG_W; b++) begin : g_bit
    localparam int LVL = level_of_bit(b);
    if (LVL >= 0) begin : g_used
      assign mon_vec[b] = src_req[LVL];
    end else begin : g_free
      assign mon_vec[b] = 1'b0;
    end
  end
endmodule

// File: rtl/irqlvl_regfile.sv
module irqlvl_regfile
  import irqlvl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic [REG_W-1:0]  mask_q,
  output logic [REG_W-1:0]  mask_nxt,
  output logic [REG_W-1:0]  gpo_q,
  output logic              pwr_fire,
  output logic              shutdown_q
);
  reg_sel_e sel;
  logic     wr_en;
  logic     wr_mask;
  logic     wr_gpo;
  logic     wr_pwr;

  assign sel     = decode_ofs(bus_addr);
  assign wr_en   = bus_sel & bus_wr;
  assign wr_mask = wr_en && (sel == SEL_MASK);
  assign wr_gpo  = wr_en && (sel == SEL_GPO);
  assign wr_pwr  = wr_en && (sel == SEL_PWR);

  // New mask is visible to the encoder in the write cycle itself
  assign mask_nxt = wr_mask ? bus_wdata : mask_q;
  assign pwr_fire = wr_pwr & bus_wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q     <= '0;
      gpo_q      <= '0;
      shutdown_q <= 1'b0;
    end else begin
      mask_q     <= mask_nxt;
      shutdown_q <= pwr_fire;
      if (wr_gpo) gpo_q <= bus_wdata;
    end
  end

  always_comb begin
    case (sel)
      SEL_MASK: bus_rdata = mask_q;
      SEL_GPO:  bus_rdata = gpo_q;
      SEL_ID:   bus_rdata = ID_VALUE;
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irqlvl_encoder.sv
module irqlvl_encoder
  import irqlvl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] mon_vec,
  input  logic [REG_W-1:0] mask_eff,
  output logic [REG_W-1:0] pend_vec,
  output logic [SRC_N-1:0] hit_vec,
  output logic [LVL_W-1:0] win_lvl,
  output logic [LVL_W-1:0] code_q
);
  assign pend_vec = mon_vec & mask_eff;

  // Regroup pending bits by priority level
  for (genvar k = 0; k < SRC_N; k++) begin : g_lvl
    localparam int BP = bit_of_level(k);
    assign hit_vec[k] = pend_vec[BP];
  end

  assign win_lvl = lowest_hit(hit_vec);

  always_ff @(posedge clk) begin
    if (!rst_n) code_q <= '0;
    else        code_q <= level_code(win_lvl);
  end
endmodule

// File: rtl/irq_level_ctrl.sv
module irq_level_ctrl
  import irqlvl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SRC_N-1:0]  src_req,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic [LVL_W-1:0]  irq_level,
  output logic [REG_W-1:0]  out_port,
  output logic              shutdown_req
);
  logic [REG_W-1:0] mon_vec;
  logic [REG_W-1:0] mask_q;
  logic [REG_W-1:0] mask_nxt;
  logic [REG_W-1:0] pend_vec;
  logic [SRC_N-1:0] hit_vec;
  logic [LVL_W-1:0] win_lvl;
  logic             pwr_fire;

  irqlvl_srcmap u_map (
    .src_req (src_req),
    .mon_vec (mon_vec)
  );

  irqlvl_regfile u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .mask_q     (mask_q),
    .mask_nxt   (mask_nxt),
    .gpo_q      (out_port),
    .pwr_fire   (pwr_fire),
    .shutdown_q (shutdown_req)
  );

  irqlvl_encoder u_enc (
    .clk      (clk),
    .rst_n    (rst_n),
    .mon_vec  (mon_vec),
    .mask_eff (mask_nxt),
    .pend_vec (pend_vec),
    .hit_vec  (hit_vec),
    .win_lvl  (win_lvl),
    .code_q   (irq_level)
  );
endmodule

// File: rtl/irqlvl_chk.sv
module irqlvl_chk
  import irqlvl_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [REG_W-1:0]  bus_wdata,
  input logic [REG_W-1:0]  bus_rdata,
  input logic [LVL_W-1:0]  irq_level,
  input logic [REG_W-1:0]  out_port,
  input logic              shutdown_req,
  input logic [REG_W-1:0]  pend_vec,
  input logic [REG_W-1:0]  mask_q
);
  logic wr_any;
  assign wr_any = bus_sel & bus_wr;

  AST_IDLE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_vec == '0) |=> (irq_level == '0)); // R4

  AST_TOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    pend_vec[11] |=> (irq_level == 4'hF)); // R3

  AST_PULSE_ON_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_any && bus_addr == 6'h30 && bus_wdata[0]) |=> shutdown_req); // R7

  AST_NO_STRAY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_any && bus_addr == 6'h30 && bus_wdata[0]) |=> !shutdown_req); // R7

  AST_MASK_STORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_any && bus_addr == 6'h00) |=> (mask_q == $past(bus_wdata))); // R5

  AST_GPO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_any && bus_addr == 6'h36) |=> $stable(out_port)); // R6

  AST_ID_CONST: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 6'h32) |-> (bus_rdata == 16'h0010)); // R8
endmodule

bind irq_level_ctrl irqlvl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_sel      (bus_sel),
  .bus_wr       (bus_wr),
  .bus_addr     (bus_addr),
  .bus_wdata    (bus_wdata),
  .bus_rdata    (bus_rdata),
  .irq_level    (irq_level),
  .out_port     (out_port),
  .shutdown_req (shutdown_req),
  .pend_vec     (pend_vec),
  .mask_q       (mask_q)
);

// File: tb/sim_irq_level_ctrl.sv
`timescale 1ns/1ps
module sim_irq_level_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] src_req = '0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [3:0]  irq_level;
  logic [15:0] out_port;
  logic        shutdown_req;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  logic sd_seen;
  logic [15:0] rd_val;

  always #2.5 clk = ~clk;

  irq_level_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .src_req(src_req),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_level(irq_level), .out_port(out_port), .shutdown_req(shutdown_req)
  );

  // Bit position per level, written from the requirement list
  int bpos [13] = '{11, 9, 8, 12, 10, 6, 5, 4, 7, 14, 13, 0, 15};

  function automatic logic [3:0] model(input logic [12:0] req, input logic [15:0] msk);
    int lv;
    lv = 15;
    for (int k = 12; k >= 0; k--)
      if (req[k] && msk[bpos[k]]) lv = k;
    return 4'(15 - lv);
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    sd_seen = shutdown_req;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [5:0] a);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 rd_val = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic sweep(input logic [15:0] msk, input string tag);
    bus_write(6'h00, msk);
    for (int p = 0; p < 8192; p++) begin
      @(negedge clk);
      src_req = 13'(p);
      @(posedge clk); #1;
      check(tag, {12'h0, irq_level}, {12'h0, model(13'(p), msk)});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    // R10 reset state
    check("R10 irq", {12'h0, irq_level}, 16'h0);
    check("R10 shutdown", {15'h0, shutdown_req}, 16'h0);
    check("R10 out_port", out_port, 16'h0);
    bus_read(6'h00); check("R10 mask", rd_val, 16'h0);

    // R4: requests with mask cleared leave output idle
    @(negedge clk) src_req = '1;
    @(posedge clk); #1;
    check("R4 all masked", {12'h0, irq_level}, 16'h0);

    // R5: mask write takes effect at the storing edge; one bit at a time
    for (int b = 0; b < 16; b++) begin
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 6'h00; bus_wdata = 16'(1 << b);
      @(posedge clk); #1;
      check("R5 mask edge", {12'h0, irq_level}, {12'h0, model('1, 16'(1 << b))});
      bus_sel = 1'b0; bus_wr = 1'b0;
    end
    bus_read(6'h00); check("R5 mask readback", rd_val, 16'h8000);

    // R1 R3: each level alone, then top level with everything
    bus_write(6'h00, 16'hFFFF);
    for (int k = 0; k < 13; k++) begin
      @(negedge clk) src_req = 13'(1 << k);
      @(posedge clk); #1;
      check("R1 single level", {12'h0, irq_level}, 16'(15 - k));
    end
    @(negedge clk) src_req = '1;
    @(posedge clk); #1;
    check("R3 level0 wins", {12'h0, irq_level}, 16'hF);

    // R11 R2: one-edge latency, release clears
    @(negedge clk) src_req = 13'h1000;
    #1 check("R11 before edge", {12'h0, irq_level}, 16'hF);
    @(posedge clk); #1;
    check("R11 after edge", {12'h0, irq_level}, 16'h3);
    @(negedge clk) src_req = '0;
    @(posedge clk); #1;
    check("R2 release", {12'h0, irq_level}, 16'h0);

    // R1 R3 R4: exhaustive sweeps under several masks
    sweep(16'hFFFF, "R3 sweep full");
    sweep(16'h5A5A, "R3 sweep 5a5a");
    sweep(16'h0E0E, "R1 sweep 0e0e");
    sweep(16'h000E, "R4 sweep unused bits");

    // R6 output register
    bus_write(6'h36, 16'hBEEF);
    check("R6 out_port", out_port, 16'hBEEF);
    bus_read(6'h36); check("R6 readback", rd_val, 16'hBEEF);
    check("R6 no pulse", {15'h0, sd_seen}, 16'h0);

    // R7 power-down control
    bus_read(6'h30); check("R7 reads zero", rd_val, 16'h0);
    bus_write(6'h30, 16'h0001);
    check("R7 pulse", {15'h0, sd_seen}, 16'h1);
    @(posedge clk); #1;
    check("R7 pulse ends", {15'h0, shutdown_req}, 16'h0);
    bus_write(6'h30, 16'hFFFE);
    check("R7 bit0 clear", {15'h0, sd_seen}, 16'h0);

    // R8 identification register
    bus_write(6'h32, 16'h1234);
    bus_read(6'h32); check("R8 id", rd_val, 16'h0010);

    // R9 undecoded offsets
    bus_write(6'h00, 16'h0A0A);
    for (int a = 0; a < 64; a++) begin
      if (a != 'h00 && a != 'h30 && a != 'h32 && a != 'h36) begin
        bus_write(6'(a), 16'hFFFF);
        check("R9 no pulse", {15'h0, sd_seen}, 16'h0);
        bus_read(6'(a));
        check("R9 reads zero", rd_val, 16'h0);
      end
    end
    bus_read(6'h00); check("R9 mask kept", rd_val, 16'h0A0A);
    check("R9 out_port kept", out_port, 16'hBEEF);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule